// File: doc/BRIEF.md
# Palette-indexed framebuffer scanout engine

This engine walks a rectangle of 8-bit pixel indices held in video memory and turns it into a stream of 24-bit RGB pixels. The start of each frame is a byte offset into video memory. The programmed width and height set the size of the rectangle. Every byte fetched is looked up in a 256-entry colour table, and the result leaves on a valid/ready stream. End-of-line and end-of-frame flags travel with the pixels. When the last pixel of a frame has been accepted downstream, an interrupt line goes high.

A register block outside the engine does three things:
- it supplies the geometry, the enable bit and the force-blank bit;
- it writes colour table entries through a dedicated write port;
- it pulses a write strobe on every register write, and that strobe lowers the interrupt.

A frame-start strobe launches one frame. Timing generation happens elsewhere. The consumer only has to obey the handshake, and it throttles the engine by holding ready low.

A three-state controller runs the frame:
- IDLE: it leaves IDLE through the *launch* transition, taken when a start strobe arrives while the block is enabled and both dimensions are non-zero.
- FETCH: it issues one memory read per cycle in which the pipeline can advance. It leaves FETCH through the *last-issued* transition once the final address of the frame has gone out.
- DRAIN: it waits there, and returns to IDLE through the *frame-accepted* transition when the end-of-frame pixel is taken downstream.

Top module: `pal_scanout`

## Requirements
- R1: A palette write with `pal_wr` high stores `pal_wdata[23:16]` as red, `[15:8]` as green and `[7:0]` as blue of entry `pal_idx`. A pixel that uses that entry shows red in `out_rgb[23:16]`, green in `[15:8]` and blue in `[7:0]`.
- R2: The first memory read of a frame uses the value of `cfg_top` sampled at launch. Each later read of the same frame uses the previous address plus one.
- R3: Pixels leave in raster order, with exactly width × height pixels per frame. `out_eol` is high on the last column of every row. `out_eof` is high only on the final pixel, which also carries `out_eol`.
- R4: Each output pixel equals the palette entry indexed by the memory byte read for it. With `out_ready` held high, the first pixel is valid two cycles after its memory read.
- R5: While `cfg_blank` is high, every output pixel is 0x000000, whatever the memory and palette contents.
- R6: A start strobe is ignored if `cfg_width` is 0, `cfg_height` is 0, or `cfg_enable` is low. In that case no read, no pixel and no interrupt follows.
- R7: `irq` rises in the cycle after the end-of-frame pixel is accepted. It stays high until a cycle with `host_wr` or `pal_wr` high lowers it.
- R8: While `out_valid` is high and `out_ready` is low, the outputs hold their values and no memory read is issued.
- R9: After reset, every palette entry is zero, `out_valid` is low and `irq` is low, so a frame scanned before any palette write is all black.
- R10: A start strobe that arrives while a frame is in progress is ignored, and the running frame completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle request to scan a frame |
| cfg_enable | input | 1 | Allows start strobes to launch a frame |
| cfg_blank | input | 1 | Forces black pixels |
| cfg_top | input | ADDR_W | Byte offset of the first pixel |
| cfg_width | input | DIM_W | Pixels per line |
| cfg_height | input | DIM_W | Lines per frame |
| host_wr | input | 1 | Register-write strobe, clears the interrupt |
| pal_wr | input | 1 | Palette entry write enable |
| pal_idx | input | IDX_W | Palette entry written |
| pal_wdata | input | 3*CH_W | Palette word {red, green, blue} |
| mem_rd | output | 1 | Video memory read request |
| mem_addr | output | ADDR_W | Video memory byte address |
| mem_rdata | input | IDX_W | Read data, valid the cycle after `mem_rd` and held until the next read |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Consumer accepts the pixel |
| out_rgb | output | 3*CH_W | Pixel colour {red, green, blue} |
| out_eol | output | 1 | Last pixel of a line |
| out_eof | output | 1 | Last pixel of the frame |
| irq | output | 1 | Frame-done interrupt |

## Verification
The bench goes after the following corner cases:
- **Backpressure.** Under random stalls, a design that let the address counter run while the pipeline was frozen would skip or repeat pixels, and the per-pixel index comparison would catch it.
- **Single-column frames.** These put `out_eol` on every pixel. An off-by-one in the column wrap would mark the wrong pixel or run one pixel too long.
- **Ignored starts.** Zero width, zero height and a disabled block must produce no output. A start strobe during a frame must not restart it at a different offset.
- **Interrupt behaviour.** The interrupt must sit high across idle cycles and fall only on a write strobe. An interrupt that cleared itself, or never rose, would show up.
- **Palette fields.** Swapped fields would recolour pixels.
- **Reset.** A palette that was not cleared at reset would leave non-black pixels in the first frame.

// File: rtl/pal_scanout_pkg.sv
package pal_scanout_pkg;

    // Frame controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a start strobe
        ST_FETCH = 2'd1,   // issuing one read per advancing cycle
        ST_DRAIN = 2'd2    // last read issued, waiting for end-of-frame acceptance
    } scan_state_e;

    // Number of register stages between a memory read and its output pixel
    localparam int PIPE_LAT = 2;

endpackage

// File: rtl/pal_lut.sv
module pal_lut #(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [3*CH_W-1:0]     wr_word,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [3*CH_W-1:0]     rd_rgb
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int RGB_W = 3 * CH_W;

    logic [RGB_W-1:0] ent_arr [DEPTH];

    // One register per entry so reset can clear the whole table at once
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic [CH_W-1:0] red_q, grn_q, blu_q;
        logic            hit;

        assign hit = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                red_q <= '0;
                grn_q <= '0;
                blu_q <= '0;
            end else if (hit) begin
                red_q <= wr_word[3*CH_W-1:2*CH_W];
                grn_q <= wr_word[2*CH_W-1:CH_W];
                blu_q <= wr_word[CH_W-1:0];
            end
        end

        assign ent_arr[e] = {red_q, grn_q, blu_q};
    end

    assign rd_rgb = ent_arr[rd_idx];

endmodule

// File: rtl/pal_scan_ctrl.sv
module pal_scan_ctrl
    import pal_scanout_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DIM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              cfg_enable,
    input  logic              cfg_blank,
    input  logic [ADDR_W-1:0] cfg_top,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic              irq_clr,
    input  logic              adv,
    input  logic              frame_acc,
    output logic              issue,
    output logic [ADDR_W-1:0] issue_addr,
    output logic              issue_eol,
    output logic              issue_eof,
    output logic              issue_blank,
    output logic              irq
);
    scan_state_e       state_q, state_d;
    logic              launch;
    logic              last_col, last_row;
    logic [ADDR_W-1:0] addr_q;
    logic [DIM_W-1:0]  col_q, row_q, wid_q, hgt_q;
    logic              irq_q;

    assign last_col = (col_q == wid_q - DIM_W'(1));
    assign last_row = (row_q == hgt_q - DIM_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and per-cycle control
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        issue   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (frame_start && cfg_enable &&
                    (cfg_width != '0) && (cfg_height != '0)) begin
                    launch  = 1'b1;
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (adv) begin
                    issue = 1'b1;
                    if (last_col && last_row) state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (frame_acc) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Raster position and address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            col_q  <= '0;
            row_q  <= '0;
            wid_q  <= '0;
            hgt_q  <= '0;
        end else if (launch) begin
            addr_q <= cfg_top;
            col_q  <= '0;
            row_q  <= '0;
            wid_q  <= cfg_width;
            hgt_q  <= cfg_height;
        end else if (issue) begin
            addr_q <= addr_q + ADDR_W'(1);
            if (last_col) begin
                col_q <= '0;
                row_q <= row_q + DIM_W'(1);
            end else begin
                col_q <= col_q + DIM_W'(1);
            end
        end
    end

    // Frame-done interrupt: setting wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (frame_acc) irq_q <= 1'b1;
        else if (irq_clr)   irq_q <= 1'b0;
    end

    assign issue_addr  = addr_q;
    assign issue_eol   = last_col;
    assign issue_eof   = last_col && last_row;
    assign issue_blank = cfg_blank;
    assign irq         = irq_q;

endmodule

// File: rtl/pal_out_pipe.sv
module pal_out_pipe #(
    parameter int CH_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              issue_eol,
    input  logic              issue_eof,
    input  logic              issue_blank,
    input  logic [3*CH_W-1:0] lut_rgb,
    input  logic              out_ready,
    output logic              adv,
    output logic              out_valid,
    output logic [3*CH_W-1:0] out_rgb,
    output logic              out_eol,
    output logic              out_eof,
    output logic              frame_acc
);
    localparam int RGB_W = 3 * CH_W;

    // Stage 1: memory data in flight; stage 2: looked-up colour
    logic             s1_v, s1_eol, s1_eof, s1_blank;
    logic             s2_v, s2_eol, s2_eof;
    logic [RGB_W-1:0] s2_rgb;

    // The whole pipe, address generation included, moves as one unit
    assign adv = !s2_v || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            s1_eol   <= 1'b0;
            s1_eof   <= 1'b0;
            s1_blank <= 1'b0;
        end else if (adv) begin
            s1_v     <= issue;
            s1_eol   <= issue_eol;
            s1_eof   <= issue_eof;
            s1_blank <= issue_blank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_v   <= 1'b0;
            s2_eol <= 1'b0;
            s2_eof <= 1'b0;
            s2_rgb <= '0;
        end else if (adv) begin
            s2_v   <= s1_v;
            s2_eol <= s1_v && s1_eol;
            s2_eof <= s1_v && s1_eof;
            s2_rgb <= s1_blank ? '0 : lut_rgb;
        end
    end

    assign out_valid = s2_v;
    assign out_rgb   = s2_rgb;
    assign out_eol   = s2_eol;
    assign out_eof   = s2_eof;
    assign frame_acc = s2_v && out_ready && s2_eof;

endmodule

// File: rtl/pal_scanout.sv
module pal_scanout #(
    parameter int ADDR_W = 24,
    parameter int DIM_W  = 12,
    parameter int IDX_W  = 8,
    parameter int CH_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                cfg_enable,
    input  logic                cfg_blank,
    input  logic [ADDR_W-1:0]   cfg_top,
    input  logic [DIM_W-1:0]    cfg_width,
    input  logic [DIM_W-1:0]    cfg_height,
    input  logic                host_wr,
    input  logic                pal_wr,
    input  logic [IDX_W-1:0]    pal_idx,
    input  logic [3*CH_W-1:0]   pal_wdata,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [IDX_W-1:0]    mem_rdata,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [3*CH_W-1:0]   out_rgb,
    output logic                out_eol,
    output logic                out_eof,
    output logic                irq
);
    localparam int RGB_W = 3 * CH_W;

    logic             adv, frame_acc;
    logic             issue, issue_eol, issue_eof, issue_blank;
    logic [RGB_W-1:0] lut_rgb;

    pal_scan_ctrl #(
        .ADDR_W (ADDR_W),
        .DIM_W  (DIM_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .cfg_enable  (cfg_enable),
        .cfg_blank   (cfg_blank),
        .cfg_top     (cfg_top),
        .cfg_width   (cfg_width),
        .cfg_height  (cfg_height),
        .irq_clr     (host_wr || pal_wr),
        .adv         (adv),
        .frame_acc   (frame_acc),
        .issue       (issue),
        .issue_addr  (mem_addr),
        .issue_eol   (issue_eol),
        .issue_eof   (issue_eof),
        .issue_blank (issue_blank),
        .irq         (irq)
    );

    pal_lut #(
        .IDX_W (IDX_W),
        .CH_W  (CH_W)
    ) u_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pal_wr),
        .wr_idx  (pal_idx),
        .wr_word (pal_wdata),
        .rd_idx  (mem_rdata),
        .rd_rgb  (lut_rgb)
    );

    pal_out_pipe #(
        .CH_W (CH_W)
    ) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (issue),
        .issue_eol   (issue_eol),
        .issue_eof   (issue_eof),
        .issue_blank (issue_blank),
        .lut_rgb     (lut_rgb),
        .out_ready   (out_ready),
        .adv         (adv),
        .out_valid   (out_valid),
        .out_rgb     (out_rgb),
        .out_eol     (out_eol),
        .out_eof     (out_eof),
        .frame_acc   (frame_acc)
    );

    assign mem_rd = issue;

endmodule

// File: rtl/pal_scanout_chk.sv
module pal_scanout_chk #(
    parameter int ADDR_W = 24,
    parameter int CH_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              pal_wr,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [3*CH_W-1:0] out_rgb,
    input logic              out_eol,
    input logic              out_eof,
    input logic              irq
);
    // R2: back-to-back reads belong to one frame and step by one byte
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && $past(mem_rd) |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    // R3: end of frame always coincides with end of line
    assert_eof_on_eol_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_eof |-> out_eol);

    // R8: a refused pixel stays put
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_rgb)
                                    && $stable(out_eol) && $stable(out_eof));

    // R8: no fetch while the consumer refuses
    assert_stall_noread_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !mem_rd);

    // R7: interrupt only rises after an accepted end-of-frame pixel
    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(out_valid && out_ready && out_eof));

    // R7: interrupt only falls after a write strobe
    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(host_wr || pal_wr));

endmodule

bind pal_scanout pal_scanout_chk #(
    .ADDR_W (ADDR_W),
    .CH_W   (CH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .pal_wr    (pal_wr),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_rgb   (out_rgb),
    .out_eol   (out_eol),
    .out_eof   (out_eof),
    .irq       (irq)
);

// File: tb/tb_pal_scanout.sv
`timescale 1ns/1ps
module tb_pal_scanout;
    localparam int ADDR_W = 24;
    localparam int DIM_W  = 12;
    localparam int IDX_W  = 8;
    localparam int CH_W   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0, cfg_enable = 1'b0, cfg_blank = 1'b0;
    logic [ADDR_W-1:0] cfg_top = '0;
    logic [DIM_W-1:0]  cfg_width = '0, cfg_height = '0;
    logic              host_wr = 1'b0, pal_wr = 1'b0;
    logic [IDX_W-1:0]  pal_idx = '0;
    logic [23:0]       pal_wdata = '0;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [IDX_W-1:0]  mem_rdata = '0;
    logic              out_valid, out_ready = 1'b1;
    logic [23:0]       out_rgb;
    logic              out_eol, out_eof, irq;

    always #5 clk = ~clk;

    pal_scanout #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .IDX_W(IDX_W), .CH_W(CH_W)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_enable(cfg_enable),
        .cfg_blank(cfg_blank), .cfg_top(cfg_top), .cfg_width(cfg_width),
        .cfg_height(cfg_height), .host_wr(host_wr), .pal_wr(pal_wr), .pal_idx(pal_idx),
        .pal_wdata(pal_wdata), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb),
        .out_eol(out_eol), .out_eof(out_eof), .irq(irq));

    // Computed video memory contents
    function automatic logic [7:0] mem_byte(logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] t;
        t = (a * 24'd37) ^ (a >> 3);
        return t[7:0] ^ t[15:8];
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= mem_byte(mem_addr);

    logic [23:0] pal_m [256];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected-frame descriptor used by the collector
    int exp_top = 0, exp_w = 1, exp_total = 0, pix_k = 0;
    bit exp_blank = 0, rnd_ready = 0;
    string rgb_req = "R4";
    int cyc = 0, first_rd = -1, first_ov = -1;
    bit stall_prev = 0;
    logic [23:0] stall_rgb = '0;

    always @(posedge clk) begin
        #1;
        out_ready = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (stall_prev)
                chk(out_valid && out_rgb == stall_rgb, "R8", "held pixel",
                    {7'd0, out_valid, out_rgb}, {8'd1, stall_rgb});
            stall_prev = 0;
            if (mem_rd && first_rd < 0) first_rd = cyc;
            if (out_valid && first_ov < 0) first_ov = cyc;
            if (out_valid && !out_ready) begin
                chk(!mem_rd, "R8", "read during stall", 32'(mem_rd), 0);
                stall_prev = 1;
                stall_rgb = out_rgb;
            end
            if (out_valid && out_ready) begin
                int k, x;
                logic [23:0] e;
                k = pix_k;
                if (k >= exp_total) begin
                    chk(0, "R3", "unexpected pixel", k, exp_total);
                end else begin
                    x = k % exp_w;
                    e = exp_blank ? 24'd0 : pal_m[mem_byte(ADDR_W'(exp_top + k))];
                    chk(out_rgb == e, rgb_req, "pixel colour", 32'(out_rgb), 32'(e));
                    chk(out_eol == (x == exp_w - 1), "R3", "eol flag", 32'(out_eol),
                        32'(x == exp_w - 1));
                    chk(out_eof == (k == exp_total - 1), "R3", "eof flag", 32'(out_eof),
                        32'(k == exp_total - 1));
                end
                pix_k++;
            end
        end
    end

    task automatic write_pal(int idx, logic [23:0] v);
        @(negedge clk);
        pal_wr = 1; pal_idx = 8'(idx); pal_wdata = v;
        @(negedge clk);
        pal_wr = 0;
        pal_m[idx] = v;
    endtask

    task automatic pulse_host_wr();
        @(negedge clk); host_wr = 1;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic arm(int top, int w, int h, bit blank, bit rnd, int total);
        exp_top = top; exp_w = (w == 0) ? 1 : w; exp_total = total;
        exp_blank = blank; rnd_ready = rnd; pix_k = 0;
        first_rd = -1; first_ov = -1;
        @(negedge clk);
        cfg_top = ADDR_W'(top); cfg_width = DIM_W'(w); cfg_height = DIM_W'(h);
        cfg_blank = blank; frame_start = 1;
        @(negedge clk);
        frame_start = 0;
    endtask

    task automatic wait_frame();
        int t = 0;
        while (pix_k < exp_total && t < 20000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_frame(int top, int w, int h, bit blank, bit rnd);
        arm(top, w, h, blank, rnd, w * h);
        wait_frame();
        chk(pix_k == w * h, "R3", "pixel count", pix_k, w * h);
        chk(irq == 1'b1, "R7", "irq after frame", 32'(irq), 1);
        if (!rnd) chk(first_ov - first_rd == 2, "R4", "read-to-pixel latency",
                      first_ov - first_rd, 2);
        chk(first_rd >= 0 && first_ov >= first_rd, "R2", "frame issued reads",
            first_rd, 0);
    endtask

    task automatic no_frame(int w, int h, string req);
        pulse_host_wr();
        arm(16, w, h, 0, 0, 0);
        repeat (30) @(negedge clk);
        chk(pix_k == 0 && first_rd < 0, req, "no output for ignored start", pix_k, 0);
        chk(irq == 1'b0, req, "no irq for ignored start", 32'(irq), 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 256; i++) pal_m[i] = 24'd0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(out_valid == 0, "R9", "out_valid in reset", 32'(out_valid), 0);
        chk(irq == 0, "R9", "irq in reset", 32'(irq), 0);
        chk(mem_rd == 0, "R9", "mem_rd in reset", 32'(mem_rd), 0);
        rst_n = 1;
        cfg_enable = 1;
        repeat (2) @(negedge clk);

        // R9: untouched palette gives black pixels
        rgb_req = "R9";
        run_frame(24'h40, 4, 2, 0, 0);
        rgb_req = "R4";

        // R1: field placement with a distinctive word, R7 clear by palette write
        write_pal(mem_byte(24'h200), 24'hAB_CD_EF);
        chk(irq == 0, "R7", "irq cleared by palette write", 32'(irq), 0);
        rgb_req = "R1";
        run_frame(24'h200, 1, 1, 0, 0);
        rgb_req = "R4";

        // Fill the palette with random colours
        for (int i = 0; i < 256; i++) write_pal(i, 24'($urandom));

        // R4: steady stream, R7 hold and clear
        run_frame(24'h100, 8, 3, 0, 0);
        repeat (10) @(negedge clk);
        chk(irq == 1, "R7", "irq holds while idle", 32'(irq), 1);
        pulse_host_wr();
        chk(irq == 0, "R7", "irq cleared by host write", 32'(irq), 0);

        // Single column: eol on every pixel (R3)
        run_frame(24'h333, 1, 5, 0, 0);

        // R8 with random backpressure, random geometry
        for (int n = 0; n < 8; n++) begin
            run_frame(int'($urandom % 24'hFFFF0), 1 + int'($urandom % 16),
                      1 + int'($urandom % 6), 0, 1);
        end

        // R5: forced blank
        run_frame(24'h500, 6, 3, 1, 1);

        // R6: ignored starts
        no_frame(0, 4, "R6");
        no_frame(5, 0, "R6");
        cfg_enable = 0;
        no_frame(5, 4, "R6");
        cfg_enable = 1;

        // R10: start during a frame is ignored
        arm(24'h700, 8, 4, 0, 1, 32);
        repeat (5) @(negedge clk);
        cfg_top = 24'h9000; cfg_width = 3; cfg_height = 1; frame_start = 1;
        @(negedge clk);
        frame_start = 0;
        wait_frame();
        chk(pix_k == 32, "R10", "frame length unchanged", pix_k, 32);
        repeat (30) @(negedge clk);
        chk(pix_k == 32, "R10", "no second frame", pix_k, 32);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R3 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule